// File: doc/BRIEF.md
# Debug Event Response Arbiter

This block decides how the processor responds to each debug event. It sees three kinds of event: a software debug event, a level-sensitive external debug request, and a halt request from the test access port. A software event arrives as a transaction and carries a type code. For each event the block looks at the global debug enable, a 2-bit mode selection, the current privilege level and a debug-permitted input. It then produces one of four responses: enter debug state, take a debug exception, take a prefetch abort, or ignore. Whenever the response is debug state entry, it also writes a 4-bit method-of-entry code.

The software event port uses a valid/ready handshake. A software event is accepted on a clock edge where `sw_valid` and `sw_ready` are both high. `sw_ready` is combinational. It goes low only in a cycle where a halt request or an external request actually fires. The source must then hold the event and its attributes stable until it is accepted. The block never blocks a software event in any other situation.

Halt and external requests that are not acted on produce no output at all. Every accepted software event produces exactly one response, which is registered and appears one cycle after acceptance. The register save and exception vectoring that follow a response are handled elsewhere.

Top module: `dbg_evt_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `resp` is 0000 and `moe_wr` is 0.
- R2: `resp` is one-hot or zero. Bit 3 means enter debug state, bit 2 debug exception, bit 1 prefetch abort, bit 0 ignore. It appears exactly one cycle after the deciding edge.
- R3: When `dbg_enable` or `dbg_permitted` is low, halt and external requests give no response. An accepted software event of type 4 (BKPT) gives a prefetch abort, and any other accepted software event gives ignore.
- R4: With debug enabled and permitted and `mode_sel`=00, accepted software events give ignore, except type 4, which gives a prefetch abort. Halt and external requests give debug state entry.
- R5: With `mode_sel`=01 or 11 (halting), with debug enabled and permitted, every known software type gives debug state entry.
- R6: With `mode_sel`=10 (monitor), with debug enabled and permitted, software events give a debug exception unless R7 applies.
- R7: In monitor mode, a vector catch (type 5) with `sw_vc_abort`=1 gives ignore. When `priv_mode`=1, an address-mismatch breakpoint (type 1) or an unlinked context-ID breakpoint (type 2) also gives ignore. With `priv_mode`=0 those two types give a debug exception.
- R8: An enabled and permitted external request gives debug state entry only in a cycle with `insn_done`=1, and it writes method code 0100.
- R9: An enabled and permitted halt request gives debug state entry with method code 0000.
- R10: Software debug state entry writes method code 0001 for breakpoint types 0, 1 and 2, 0010 for a watchpoint (type 3), 0011 for BKPT (type 4) and 0101 for a vector catch (type 5).
- R11: Within one cycle the priority is halt, then external, then software. `sw_ready` is low exactly when a halt or external request fires, and a software event held across that cycle is answered afterwards.
- R12: Software type codes 6 and 7 always give ignore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_enable | input | 1 | Global debug enable |
| dbg_permitted | input | 1 | Core state permits debug |
| mode_sel | input | 2 | 00 none, 01/11 halting, 10 monitor |
| priv_mode | input | 1 | Core in a privileged mode |
| halt_req | input | 1 | Halt request from the test access port |
| ext_req | input | 1 | External debug request level |
| insn_done | input | 1 | Current instruction completes this cycle |
| sw_valid | input | 1 | Software event valid |
| sw_ready | output | 1 | Software event accepted this cycle when valid |
| sw_kind | input | 3 | Software event type code |
| sw_vc_abort | input | 1 | Vector catch is on an abort vector |
| resp | output | 4 | One-hot response |
| moe_wr | output | 1 | Method-of-entry write strobe |
| moe_code | output | 4 | Method-of-entry code |

## Verification
The bench sweeps every combination of mode, enable, permission, privilege, type and abort flag. This exposes a design that treats mode 11 as monitor, or that leaves BKPT ignored instead of aborting when debug is off. It also targets the monitor exclusions from both sides, so a design that ignores mismatch breakpoints in user mode is caught, and so is one that lets abort vector catches through. Same-cycle collisions check that a displaced software event is held rather than dropped. External requests are held across cycles without instruction completion, so a design that acts on the level alone answers too early.

// File: rtl/dbg_arb_pkg.sv
package dbg_arb_pkg;
  localparam int KIND_W = 3;
  localparam int MODE_W = 2;
  localparam int MOE_W  = 4;
  localparam int RESP_W = 4;

  localparam int RSP_ENTER = 3;
  localparam int RSP_EXC   = 2;
  localparam int RSP_PABT  = 1;
  localparam int RSP_IGN   = 0;

  localparam logic [KIND_W-1:0] EV_BP_ADDR = 3'd0;
  localparam logic [KIND_W-1:0] EV_BP_MISM = 3'd1;
  localparam logic [KIND_W-1:0] EV_BP_CTX  = 3'd2;
  localparam logic [KIND_W-1:0] EV_WATCH   = 3'd3;
  localparam logic [KIND_W-1:0] EV_BKPT    = 3'd4;
  localparam logic [KIND_W-1:0] EV_VCATCH  = 3'd5;

  localparam logic [MOE_W-1:0] MOE_HALT  = 4'b0000;
  localparam logic [MOE_W-1:0] MOE_BP    = 4'b0001;
  localparam logic [MOE_W-1:0] MOE_WATCH = 4'b0010;
  localparam logic [MOE_W-1:0] MOE_BKPT  = 4'b0011;
  localparam logic [MOE_W-1:0] MOE_EXT   = 4'b0100;
  localparam logic [MOE_W-1:0] MOE_VC    = 4'b0101;

  typedef struct packed {
    logic [RESP_W-1:0] resp;
    logic [MOE_W-1:0]  moe;
  } decision_t;
endpackage

// File: rtl/dbg_sw_classify.sv
module dbg_sw_classify
  import dbg_arb_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic              vc_abort,
  input  logic              dbg_enable,
  input  logic              dbg_permitted,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              priv_mode,
  output decision_t         dec
);
  logic active, halting, monitor, known, excluded;
  logic [MOE_W-1:0] kind_moe;

  always_comb begin
    active  = dbg_enable && dbg_permitted && (mode_sel != '0);
    halting = active && mode_sel[0];
    monitor = active && (mode_sel == 2'b10);
    known   = (kind <= EV_VCATCH);
    excluded = ((kind == EV_VCATCH) && vc_abort) ||
               (priv_mode && ((kind == EV_BP_MISM) || (kind == EV_BP_CTX)));
    unique case (kind)
      EV_BP_ADDR, EV_BP_MISM, EV_BP_CTX: kind_moe = MOE_BP;
      EV_WATCH:                          kind_moe = MOE_WATCH;
      EV_BKPT:                           kind_moe = MOE_BKPT;
      default:                           kind_moe = MOE_VC;
    endcase
  end

  always_comb begin
    dec.resp = '0;
    dec.moe  = '0;
    if (!known) begin
      dec.resp[RSP_IGN] = 1'b1;
    end else if (halting) begin
      dec.resp[RSP_ENTER] = 1'b1;
      dec.moe = kind_moe;
    end else if (monitor) begin
      if (excluded) dec.resp[RSP_IGN] = 1'b1;
      else          dec.resp[RSP_EXC] = 1'b1;
    end else if (kind == EV_BKPT) begin
      dec.resp[RSP_PABT] = 1'b1;
    end else begin
      dec.resp[RSP_IGN] = 1'b1;
    end
  end
endmodule

// File: rtl/dbg_req_select.sv
module dbg_req_select
  import dbg_arb_pkg::*;
(
  input  logic      halt_req,
  input  logic      ext_req,
  input  logic      insn_done,
  input  logic      en_ok,
  input  logic      sw_valid,
  input  decision_t sw_dec,
  output logic      sw_ready,
  output decision_t nxt
);
  logic halt_fire, ext_fire;

  always_comb begin
    halt_fire = halt_req && en_ok;
    ext_fire  = ext_req && insn_done && en_ok && !halt_fire;
    sw_ready  = !halt_fire && !ext_fire;
    nxt = '0;
    if (halt_fire) begin
      nxt.resp[RSP_ENTER] = 1'b1;
      nxt.moe = MOE_HALT;
    end else if (ext_fire) begin
      nxt.resp[RSP_ENTER] = 1'b1;
      nxt.moe = MOE_EXT;
    end else if (sw_valid) begin
      nxt = sw_dec;
    end
  end
endmodule

// File: rtl/dbg_resp_reg.sv
module dbg_resp_reg
  import dbg_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  decision_t         d,
  output logic [RESP_W-1:0] resp,
  output logic              moe_wr,
  output logic [MOE_W-1:0]  moe_code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp     <= '0;
      moe_wr   <= 1'b0;
      moe_code <= '0;
    end else begin
      resp     <= d.resp;
      moe_wr   <= d.resp[RSP_ENTER];
      moe_code <= d.resp[RSP_ENTER] ? d.moe : moe_code;
    end
  end

  p_resp_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(resp));
  p_moe_with_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    moe_wr == resp[RSP_ENTER]);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (resp == '0 && !moe_wr));
endmodule

// File: rtl/dbg_evt_arbiter.sv
module dbg_evt_arbiter
  import dbg_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_enable,
  input  logic              dbg_permitted,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              priv_mode,
  input  logic              halt_req,
  input  logic              ext_req,
  input  logic              insn_done,
  input  logic              sw_valid,
  output logic              sw_ready,
  input  logic [KIND_W-1:0] sw_kind,
  input  logic              sw_vc_abort,
  output logic [RESP_W-1:0] resp,
  output logic              moe_wr,
  output logic [MOE_W-1:0]  moe_code
);
  decision_t sw_dec, nxt;
  logic en_ok;

  assign en_ok = dbg_enable && dbg_permitted;

  dbg_sw_classify u_classify (
    .kind(sw_kind), .vc_abort(sw_vc_abort), .dbg_enable(dbg_enable),
    .dbg_permitted(dbg_permitted), .mode_sel(mode_sel), .priv_mode(priv_mode),
    .dec(sw_dec)
  );

  dbg_req_select u_select (
    .halt_req(halt_req), .ext_req(ext_req), .insn_done(insn_done), .en_ok(en_ok),
    .sw_valid(sw_valid), .sw_dec(sw_dec), .sw_ready(sw_ready), .nxt(nxt)
  );

  dbg_resp_reg u_reg (
    .clk(clk), .rst_n(rst_n), .d(nxt),
    .resp(resp), .moe_wr(moe_wr), .moe_code(moe_code)
  );

  p_disabled_no_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbg_enable && dbg_permitted) |=> !resp[RSP_ENTER] && !resp[RSP_EXC]);
  p_halt_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && dbg_enable && dbg_permitted) |=> (moe_wr && moe_code == MOE_HALT));
  p_ext_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_req && ext_req && insn_done && dbg_enable && dbg_permitted)
      |=> (moe_wr && moe_code == MOE_EXT));
  p_ext_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_req && !insn_done && !sw_valid) |=> resp == '0);
  p_monitor_no_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid && sw_ready && mode_sel == 2'b10) |=> !resp[RSP_ENTER]);
  p_ready_yields_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && dbg_enable && dbg_permitted) |-> !sw_ready);
endmodule

// File: tb/dbg_evt_arbiter_bench.sv
module dbg_evt_arbiter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_enable = 0, dbg_permitted = 0, priv_mode = 0;
  logic [1:0] mode_sel = 0;
  logic halt_req = 0, ext_req = 0, insn_done = 0, sw_valid = 0, sw_vc_abort = 0;
  logic [2:0] sw_kind = 0;
  logic sw_ready, moe_wr;
  logic [3:0] resp, moe_code;

  int checks = 0, failures = 0;
  int exp_resp = 0, exp_wr = 0, exp_moe = 0;
  int last_moe = 0;
  string exp_tag = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  dbg_evt_arbiter u_dbg_evt_arbiter (
    .clk(clk), .rst_n(rst_n), .dbg_enable(dbg_enable), .dbg_permitted(dbg_permitted),
    .mode_sel(mode_sel), .priv_mode(priv_mode), .halt_req(halt_req), .ext_req(ext_req),
    .insn_done(insn_done), .sw_valid(sw_valid), .sw_ready(sw_ready), .sw_kind(sw_kind),
    .sw_vc_abort(sw_vc_abort), .resp(resp), .moe_wr(moe_wr), .moe_code(moe_code)
  );

  // Reference: response bits 8=enter 4=exc 2=pabt 1=ignore; tag names governing requirement
  function automatic void model(output int r, output int m, output bit rdy, output string tag);
    bit en = dbg_enable && dbg_permitted;
    bit hf = halt_req && en;
    bit ef = ext_req && insn_done && en && !hf;
    r = 0; m = 0; rdy = !(hf || ef); tag = "R2";
    if (hf) begin r = 8; m = 0; tag = "R9"; end
    else if (ef) begin r = 8; m = 4; tag = "R8"; end
    else if (sw_valid) begin
      int k = sw_kind;
      if (halt_req || ext_req) tag = "R11";
      if (k > 5) begin r = 1; tag = "R12"; end
      else if (!en) begin r = (k == 4) ? 2 : 1; tag = "R3"; end
      else if (mode_sel == 2'b00) begin r = (k == 4) ? 2 : 1; tag = "R4"; end
      else if (mode_sel == 2'b10) begin
        if ((k == 5 && sw_vc_abort) || (priv_mode && (k == 1 || k == 2))) begin
          r = 1; tag = "R7";
        end else begin
          r = 4; tag = (k == 1 || k == 2 || k == 5) ? "R7" : "R6";
        end
      end else begin
        r = 8; tag = "R10";
        case (k)
          0, 1, 2: m = 1;
          3: m = 2;
          4: m = 3;
          default: m = 5;
        endcase
        if (k == 0) tag = "R5";
      end
    end
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        check(resp == 0 && !moe_wr, "R1", "reset outputs", {moe_wr, resp}, 0);
        exp_resp = 0; exp_wr = 0; exp_tag = "R1";
      end else begin
        int r, m; bit rdy; string tg;
        check(int'(resp) == exp_resp, exp_tag, "resp", resp, exp_resp);
        check(int'(moe_wr) == exp_wr, exp_tag, "moe_wr", moe_wr, exp_wr);
        if (exp_wr != 0) last_moe = exp_moe;
        if (exp_wr != 0) check(int'(moe_code) == exp_moe, exp_tag, "moe_code", moe_code, exp_moe);
        model(r, m, rdy, tg);
        check(sw_ready == rdy, "R11", "sw_ready", sw_ready, rdy);
        exp_resp = r; exp_wr = (r == 8); exp_moe = m; exp_tag = tg;
      end
    end
  end

  task automatic step(); @(posedge clk); #2; endtask

  task automatic idle(); halt_req = 0; ext_req = 0; insn_done = 0; sw_valid = 0; endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(); step(); step();
    rst_n = 1;
    step(); step();
    // Full sweep of software decisions (R3..R7, R10, R12)
    for (int mo = 0; mo < 4; mo++)
      for (int ep = 0; ep < 4; ep++)
        for (int pv = 0; pv < 2; pv++)
          for (int k = 0; k < 8; k++)
            for (int va = 0; va < 2; va++) begin
              mode_sel = 2'(mo); dbg_enable = ep[0]; dbg_permitted = ep[1];
              priv_mode = pv[0]; sw_kind = 3'(k); sw_vc_abort = va[0];
              sw_valid = 1; step();
              sw_valid = 0; step();
            end
    // R8: external waits for instruction completion
    dbg_enable = 1; dbg_permitted = 1; mode_sel = 2'b00;
    ext_req = 1; insn_done = 0; step(); step();
    insn_done = 1; step(); idle(); step();
    // R3: disabled halt and external give nothing
    dbg_enable = 0; halt_req = 1; step();
    ext_req = 1; insn_done = 1; halt_req = 0; step(); idle();
    dbg_enable = 1; dbg_permitted = 0; halt_req = 1; step(); idle(); step();
    // R9 / R4: halt in mode none
    dbg_permitted = 1; halt_req = 1; step(); idle(); step();
    // R11: all three collide; software event held until accepted
    mode_sel = 2'b01; sw_kind = 3'd3; sw_valid = 1;
    halt_req = 1; ext_req = 1; insn_done = 1; step();
    halt_req = 0; step();
    ext_req = 0; step();
    sw_valid = 0; step();
    // R11: disabled halt does not displace software
    dbg_enable = 0; halt_req = 1; sw_valid = 1; sw_kind = 3'd4; step();
    idle(); step();
    // R7 / R6 in monitor with user mode
    dbg_enable = 1; mode_sel = 2'b10; priv_mode = 0; sw_kind = 3'd1; sw_valid = 1; step();
    sw_kind = 3'd2; step();
    idle(); step(); step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule